// File: doc/BRIEF.md
# Fixed-Period PWM Generator

This block drives one pulse-width-modulated line whose period never changes. Each period is cut into 2^DATA_W equal steps (256 by default), and each step lasts CLKS_PER_STEP system clocks. A step prescaler and a free-running phase counter keep counting from reset onward. Enabling, disabling or changing the duty does not restart them.

A small register port holds two 8-bit registers. The settings register carries the output-enable bit; its remaining bits are plain storage. The duty register holds a code D. The high time is D+1 steps, so the shortest pulse is one step and a code of 255 gives a line that is high for the whole period. A 0% duty cycle cannot be produced while the output is enabled. To hold the line low, software clears the enable bit: the block stops driving the pin and an external pull-down takes it low. Writes take effect at once, even in the middle of a period, and the glitch this can cause in that period is accepted.

Top module: `fixed_pwm_gen`

## Requirements
- R1: While reset is held, pwm_oe, pwm_o, period_start and rdata are 0. After reset, both registers read back as 0.
- R2: period_start is a one-clock pulse that repeats every CLKS_PER_STEP*256 clocks.
- R3: In a period during which the duty code D does not change, pwm_o is high for exactly (D+1)*CLKS_PER_STEP clocks, counted from the clock that carries period_start. D=0 gives one step of high time. D=255 keeps pwm_o high for the whole period, and pwm_o is high in every clock that carries period_start.
- R4: Bit 7 of the settings register (address 0xD2) drives pwm_oe, which follows a write to that bit two clocks after the write clock.
- R5: Bits 6:0 of the settings register are read/write storage with no other effect.
- R6: The duty register at address 0xD8 reads back the last value written to it.
- R7: A duty write in the middle of a period changes pwm_o two clocks after the write clock. It does not move the next period_start.
- R8: Toggling the enable bit in the middle of a period does not move the next period_start.
- R9: A read of any address other than 0xD2 or 0xD8 returns 0. A write to such an address changes neither register nor pwm_oe.
- R10: rdata is registered: it carries the read value in the clock after rd_en and is 0 in any clock that follows a clock without rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| pwm_o | output | 1 | PWM data level |
| pwm_oe | output | 1 | Pin drive enable (low leaves the line to the pull-down) |
| period_start | output | 1 | One-clock pulse when a period begins |

## Verification
The hardest case to reach is a change that lands in the middle of a period while the period grid must stay where it was. The bench finds a period_start and counts clocks from it. At a chosen offset it issues a duty or enable write, then checks pwm_o two clocks later and checks that the next period_start comes exactly one period after the last one. To keep each period short, the bench sets the prescaler to three clocks per step. Exact high-time counts for the extreme codes 0 and 255 are measured only after a settle margin, so that no write overlaps the measured period.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  localparam int unsigned DEF_DATA_W    = 8;
  localparam int unsigned DEF_ADDR_W    = 8;
  localparam int unsigned DEF_CFG_ADDR  = 32'hD2;
  localparam int unsigned DEF_DUTY_ADDR = 32'hD8;
  localparam int unsigned DEF_EN_BIT    = 7;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_DUTY = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/fpwm_prescaler.sv
module fpwm_prescaler #(
  parameter int unsigned CLKS_PER_STEP = 100
) (
  input  logic clk,
  input  logic rst,
  output logic step_tick
);
  generate
    if (CLKS_PER_STEP <= 1) begin : g_every_clk
      assign step_tick = 1'b1;
    end else begin : g_count
      localparam int unsigned CW = $clog2(CLKS_PER_STEP);
      localparam logic [CW-1:0] LAST = CW'(CLKS_PER_STEP - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end

      assign step_tick = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/fpwm_phase.sv
module fpwm_phase #(
  parameter int unsigned PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_tick,
  output logic [PHASE_W-1:0] phase,
  output logic               wrap
);
  always_ff @(posedge clk) begin
    if (rst)            phase <= '0;
    else if (step_tick) phase <= phase + 1'b1;
  end

  assign wrap = step_tick && (&phase);
endmodule

// File: rtl/fpwm_regs.sv
module fpwm_regs
  import fpwm_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned CFG_ADDR  = DEF_CFG_ADDR,
  parameter int unsigned DUTY_ADDR = DEF_DUTY_ADDR,
  parameter int unsigned EN_BIT    = DEF_EN_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] duty_q,
  output logic              out_en
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] cfg_q;

  always_comb begin
    if (addr == ADDR_W'(CFG_ADDR))       sel = SEL_CFG;
    else if (addr == ADDR_W'(DUTY_ADDR)) sel = SEL_DUTY;
    else                                 sel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      duty_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_CFG:  cfg_q  <= wdata;
        SEL_DUTY: duty_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (sel)
        SEL_CFG:  rdata <= cfg_q;
        SEL_DUTY: rdata <= duty_q;
        default:  rdata <= '0;
      endcase
    end else rdata <= '0;
  end

  assign out_en = cfg_q[EN_BIT];
endmodule

// File: rtl/fpwm_compare.sv
module fpwm_compare #(
  parameter int unsigned PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase,
  input  logic [PHASE_W-1:0] duty,
  input  logic               out_en,
  input  logic               wrap,
  output logic               pwm_o,
  output logic               pwm_oe,
  output logic               period_start
);
  logic wrap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrap_q       <= 1'b0;
      pwm_o        <= 1'b0;
      pwm_oe       <= 1'b0;
      period_start <= 1'b0;
    end else begin
      wrap_q       <= wrap;
      pwm_o        <= (phase <= duty);
      pwm_oe       <= out_en;
      period_start <= wrap_q;
    end
  end
endmodule

// File: rtl/fixed_pwm_gen.sv
module fixed_pwm_gen
  import fpwm_pkg::*;
#(
  parameter int unsigned CLKS_PER_STEP = 100,
  parameter int unsigned ADDR_W        = DEF_ADDR_W,
  parameter int unsigned DATA_W        = DEF_DATA_W,
  parameter int unsigned CFG_ADDR      = DEF_CFG_ADDR,
  parameter int unsigned DUTY_ADDR     = DEF_DUTY_ADDR,
  parameter int unsigned EN_BIT        = DEF_EN_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pwm_o,
  output logic              pwm_oe,
  output logic              period_start
);
  localparam int unsigned PHASE_W = DATA_W;

  logic               step_tick;
  logic               wrap;
  logic               out_en;
  logic [PHASE_W-1:0] phase;
  logic [DATA_W-1:0]  duty_q;

  fpwm_prescaler #(.CLKS_PER_STEP(CLKS_PER_STEP)) u_presc (
    .clk(clk), .rst(rst), .step_tick(step_tick)
  );

  fpwm_phase #(.PHASE_W(PHASE_W)) u_phase (
    .clk(clk), .rst(rst), .step_tick(step_tick), .phase(phase), .wrap(wrap)
  );

  fpwm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR),
    .DUTY_ADDR(DUTY_ADDR), .EN_BIT(EN_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .duty_q(duty_q), .out_en(out_en)
  );

  fpwm_compare #(.PHASE_W(PHASE_W)) u_cmp (
    .clk(clk), .rst(rst), .phase(phase), .duty(duty_q), .out_en(out_en),
    .wrap(wrap), .pwm_o(pwm_o), .pwm_oe(pwm_oe), .period_start(period_start)
  );
endmodule

// File: rtl/fixed_pwm_gen_chk.sv
module fixed_pwm_gen_chk #(
  parameter int unsigned CLKS_PER_STEP = 100,
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CFG_ADDR      = 32'hD2,
  parameter int unsigned DUTY_ADDR     = 32'hD8,
  parameter int unsigned EN_BIT        = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              pwm_o,
  input logic              pwm_oe,
  input logic              period_start,
  input logic [DATA_W-1:0] duty_q
);
  localparam int unsigned PERIOD = CLKS_PER_STEP << DATA_W;
  localparam int unsigned CW     = $clog2(PERIOD) + 1;

  logic [CW-1:0] since_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (period_start) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else begin
      since_q <= since_q + 1'b1;
    end
  end

  AST_PERIOD_SPACING: assert property (@(posedge clk) disable iff (rst)
    (period_start && seen_q) |-> (since_q == CW'(PERIOD - 1))); // R2
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    period_start |=> !period_start); // R2
  AST_PHASE0_HIGH: assert property (@(posedge clk) disable iff (rst)
    period_start |-> pwm_o); // R3
  AST_OE_TRACKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(CFG_ADDR)) |=> ##1 (pwm_oe == $past(wdata[EN_BIT], 2))); // R4
  AST_DUTY_READBACK: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(DUTY_ADDR)) |=> (rdata == $past(duty_q))); // R6
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != ADDR_W'(CFG_ADDR) && addr != ADDR_W'(DUTY_ADDR)) |=> (rdata == '0)); // R9
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0)); // R10
endmodule

bind fixed_pwm_gen fixed_pwm_gen_chk #(
  .CLKS_PER_STEP(CLKS_PER_STEP), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CFG_ADDR(CFG_ADDR), .DUTY_ADDR(DUTY_ADDR), .EN_BIT(EN_BIT)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o), .pwm_oe(pwm_oe),
  .period_start(period_start), .duty_q(duty_q)
);

// File: tb/test_fixed_pwm_gen.sv
`timescale 1ns/1ps
module test_fixed_pwm_gen;
  localparam int CPS = 3;
  localparam int PER = CPS * 256;
  localparam logic [7:0] A_CFG  = 8'hD2;
  localparam logic [7:0] A_DUTY = 8'hD8;

  typedef struct packed { logic [7:0] duty; logic [15:0] highs; } vec_t;
  localparam vec_t VECS [5] = '{
    '{8'd0,   16'd3},   '{8'd1,   16'd6},   '{8'd127, 16'd384},
    '{8'd200, 16'd603}, '{8'd255, 16'd768}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       pwm_o, pwm_oe, period_start;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  fixed_pwm_gen #(.CLKS_PER_STEP(CPS)) i_fixed_pwm_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o), .pwm_oe(pwm_oe),
    .period_start(period_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    v = rdata;
    rd_en = 1'b0;
  endtask

  task automatic find_start();
    repeat (3) @(negedge clk);
    while (!period_start) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    int highs, extra;
    repeat (4) @(negedge clk);
    // R1: outputs quiet while reset held
    check(pwm_oe == 0 && pwm_o == 0 && period_start == 0 && rdata == 0, "R1 outputs in reset",
          {pwm_oe, pwm_o, period_start}, 0);
    rst = 1'b0;
    @(negedge clk);
    rd(A_CFG, v);  check(v == 0, "R1 settings after reset", v, 0);
    rd(A_DUTY, v); check(v == 0, "R1 duty after reset", v, 0);
    @(negedge clk);
    check(rdata == 0, "R10 rdata idle after read", rdata, 0);

    // R5: low settings bits are storage
    wr(A_CFG, 8'h55); rd(A_CFG, v); check(v == 8'h55, "R5 settings readback", v, 8'h55);
    @(negedge clk);
    check(pwm_oe == 0, "R5 low bits leave oe clear", pwm_oe, 0);

    // R4: enable bit timing
    wr_en = 1'b1; addr = A_CFG; wdata = 8'h80;
    @(negedge clk); wr_en = 1'b0;
    check(pwm_oe == 0, "R4 oe not yet set one clock after write", pwm_oe, 0);
    @(negedge clk);
    check(pwm_oe == 1, "R4 oe set two clocks after write", pwm_oe, 1);

    // R6: duty readback
    wr(A_DUTY, 8'hA7); rd(A_DUTY, v); check(v == 8'hA7, "R6 duty readback", v, 8'hA7);

    // R9: unmapped addresses
    wr(8'h10, 8'h33); wr(8'hD3, 8'h00);
    rd(A_CFG, v);  check(v == 8'h80, "R9 settings unchanged", v, 8'h80);
    rd(A_DUTY, v); check(v == 8'hA7, "R9 duty unchanged", v, 8'hA7);
    rd(8'h10, v);  check(v == 0, "R9 unmapped read zero", v, 0);
    check(pwm_oe == 1, "R9 oe unchanged", pwm_oe, 1);

    // R2/R3: vector table of duty codes
    foreach (VECS[k]) begin
      wr(A_DUTY, VECS[k].duty);
      find_start();
      highs = 0; extra = 0;
      for (int i = 0; i < PER; i++) begin
        if (pwm_o) highs++;
        if (i > 0 && period_start) extra++;
        @(negedge clk);
      end
      check(highs == int'(VECS[k].highs), "R3 high clocks per period", highs, VECS[k].highs);
      check(extra == 0 && period_start == 1, "R2 period spacing", extra, 0);
    end

    // R7: mid-period duty change
    wr(A_DUTY, 8'hFF);
    find_start();
    for (int i = 0; i <= PER; i++) begin
      if (i == 101) check(pwm_o == 1, "R7 old duty one clock after write", pwm_o, 1);
      if (i == 102) check(pwm_o == 0, "R7 new duty two clocks after write", pwm_o, 0);
      if (i == PER) check(period_start == 1, "R7 period grid kept", period_start, 1);
      wr_en = (i == 100); addr = A_DUTY; wdata = 8'h00;
      if (i < PER) @(negedge clk);
    end
    wr_en = 1'b0;

    // R8: mid-period enable toggle
    find_start();
    for (int i = 0; i <= PER; i++) begin
      if (i == PER) begin
        check(period_start == 1, "R8 period grid kept across disable", period_start, 1);
        check(pwm_oe == 0, "R8 oe cleared", pwm_oe, 0);
      end
      wr_en = (i == 40); addr = A_CFG; wdata = 8'h00;
      if (i < PER) @(negedge clk);
    end
    wr_en = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule